// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two 32-bit operands over several clock cycles and returns a 64-bit product. It uses one 32-bit adder. A 64-bit working register holds the partial product in its upper half and the multiplier operand in its lower half. On every step the block looks at bit 0 of the working register. If that bit is 1, it adds the multiplicand into the upper half. It then shifts the whole register right by one, and the carry of the add enters bit 63. After one step per multiplier bit, the register holds the complete product.

A caller raises `start` for one cycle while the block is idle. At that moment the block captures both operands and the `signedMode` selection. `busy` stays high while the operation runs. `done` pulses for exactly one cycle when `product` takes the new value. In signed mode the block works on magnitudes and negates the result when the operand signs differed. The magnitude path is unsigned and W bits wide, so the most negative operand is handled correctly.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: When `start` is 1 while `busy` is 0, the operation is accepted. `busy` is 1 from the next cycle for exactly W+1 cycles (33 with defaults), and then returns to 0.
- R3: `done` is 1 for exactly one cycle. That is the first cycle after an operation in which `busy` is 0.
- R4: With `signedMode` 0, the operands are unsigned and `product` equals their full 2W-bit unsigned product. This includes all-ones times all-ones, where every add carries out.
- R5: With `signedMode` 1, the operands are two's complement and `product` equals their 2W-bit two's complement product. The result is negative exactly when the signs differ and neither operand is zero.
- R6: In signed mode, an operand equal to the most negative value (0x80000000) gives the correct product. 0x80000000 times 0x80000000 gives 0x4000000000000000, and 0x80000000 times 1 gives 0xFFFFFFFF80000000.
- R7: `start` while `busy` is 1 has no effect. The running operation ends at its normal time with its own result, and no second operation follows.
- R8: `product` changes only in the cycle in which `done` is 1. It holds its value while idle and while a later operation runs.
- R9: The operands and `signedMode` are captured only when an operation is accepted. Changing them while `busy` is 1 does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new multiplication when idle |
| signedMode | input | 1 | 1: operands are two's complement; 0: unsigned |
| multiplicand | input | W (32) | First operand |
| multiplier | input | W (32) | Second operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: `product` has just been updated |
| product | output | 2W (64) | Result of the last completed operation |

## Verification
A wrong step count, a lost carry, or a bad shift in the working register cannot be seen at the ports while the block runs. It shows only when `product` is updated. A mistake in the sequencing shows earlier: `busy` falls one cycle too early or too late, or `done` comes at the wrong time. The reference model in the bench tracks `busy`, `done` and `product` on every clock, so a timing fault is reported in the first cycle it occurs and a value fault at the `done` pulse of the affected operation. The operand sets include full carry chains, mixed signs, zero and the most negative value. Restarts during `busy` and operand changes during `busy` show whether the control and the operand capture are sealed against outside input.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;

  // Control state of the multiplier sequence
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } mulState_t;

  // Strobes from the control to the datapath, at most one high per cycle
  typedef struct packed {
    logic load;    // capture operands and magnitudes
    logic step;    // one conditional add plus right shift
    logic finish;  // apply sign and publish the result
  } mulStrobe_t;

endpackage

// File: rtl/sam_ctrl.sv
module sam_ctrl
  import shift_add_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output mulStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mulState_t state;
  logic [CW-1:0] stepCnt;

  always_comb begin
    strobe.load   = (state == ST_IDLE) && start;
    strobe.step   = (state == ST_RUN);
    strobe.finish = (state == ST_FIX);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.finish;
      unique case (state)
        ST_IDLE: begin
          stepCnt <= '0;
          if (start) state <= ST_RUN;
        end
        ST_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sam_datapath.sv
module sam_datapath
  import shift_add_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  mulStrobe_t     strobe,
  input  logic           signedMode,
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  output logic [2*W-1:0] result
);
  localparam int PW = 2 * W;

  logic [PW-1:0] work;     // upper half: partial sum, lower half: multiplier bits
  logic [W-1:0]  mcand;    // multiplicand magnitude
  logic          negFlag;  // result needs negation

  logic [W-1:0] magA, magB;
  logic         negA, negB;
  logic [W-1:0] addend;
  logic [W:0]   addSum;

  // Magnitudes are W-bit unsigned, so the most negative value maps onto itself
  always_comb begin
    negA   = signedMode && opA[W-1];
    negB   = signedMode && opB[W-1];
    magA   = negA ? (~opA + 1'b1) : opA;
    magB   = negB ? (~opB + 1'b1) : opB;
    addend = work[0] ? mcand : '0;
    addSum = {1'b0, work[PW-1:W]} + {1'b0, addend};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      work    <= '0;
      mcand   <= '0;
      negFlag <= 1'b0;
      result  <= '0;
    end else if (strobe.load) begin
      work    <= {{W{1'b0}}, magB};
      mcand   <= magA;
      negFlag <= negA ^ negB;
    end else if (strobe.step) begin
      // Carry-out enters the top bit as everything moves right by one
      work <= {addSum, work[W-1:1]};
    end else if (strobe.finish) begin
      result <= negFlag ? (~work + 1'b1) : work;
    end
  end
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import shift_add_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           signedMode,
  input  logic [W-1:0]   multiplicand,
  input  logic [W-1:0]   multiplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  mulStrobe_t strobe;

  sam_ctrl #(.W(W)) ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strobe(strobe),
    .busy  (busy),
    .done  (done)
  );

  sam_datapath #(.W(W)) dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .signedMode(signedMode),
    .opA       (multiplicand),
    .opB       (multiplier),
    .result    (product)
  );
endmodule

// File: rtl/sam_checker.sv
module sam_checker #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product
);
  logic [15:0] busyLen;

  always_ff @(posedge clk) begin
    if (!rstN) busyLen <= '0;
    else       busyLen <= busy ? busyLen + 1'b1 : '0;
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == 16'(W + 1)));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_at_end_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(product));
endmodule

bind shift_add_mul sam_checker #(.W(W)) chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .product(product)
);

// File: tb/shift_add_mul_test.sv
module shift_add_mul_test;
  localparam int W = 32;
  localparam int PERIOD = 10;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic signedMode = 1'b0;
  logic [W-1:0] mA = '0, mB = '0;
  logic busy, done;
  logic [2*W-1:0] product;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(PERIOD/2) clk = ~clk;

  shift_add_mul #(.W(W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .multiplicand(mA), .multiplier(mB),
    .busy(busy), .done(done), .product(product)
  );

  function automatic logic [2*W-1:0] refMul(logic [W-1:0] a, logic [W-1:0] b, logic s);
    logic [2*W-1:0] ea, eb;
    ea = s ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    eb = s ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    return ea * eb;
  endfunction

  // Behavioural reference model, advanced on every rising edge
  logic mBusy = 1'b0, mDone = 1'b0;
  int mLeft = 0;
  logic [2*W-1:0] mProd = '0, mPend = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy <= 1'b0; mDone <= 1'b0; mLeft <= 0; mProd <= '0;
    end else begin
      mDone <= 1'b0;
      if (mBusy) begin
        if (mLeft == 1) begin
          mBusy <= 1'b0; mDone <= 1'b1; mProd <= mPend;
        end else mLeft <= mLeft - 1;
      end else if (start) begin
        mBusy <= 1'b1; mLeft <= W + 1;
        mPend <= refMul(mA, mB, signedMode);
      end
    end
  end

  task automatic check(string tag, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check("R2 busy", 64'(busy), 64'(mBusy));
      check("R3 done", 64'(done), 64'(mDone));
      check("R8 product", product, mProd);
    end
    if (cycles > LIMIT) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic runOp(string tag, logic [W-1:0] a, logic [W-1:0] b, logic s,
                       bit poke);
    logic [2*W-1:0] exp;
    exp = refMul(a, b, s);
    @(negedge clk);
    mA = a; mB = b; signedMode = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R7 / R9: disturb inputs while busy
      repeat (5) @(negedge clk);
      mA = ~a; mB = b + 1; signedMode = ~s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    check(tag, product, exp);
    @(negedge clk);
    check({tag, " hold R8"}, product, exp);
    check({tag, " idle R7"}, 64'(busy), 64'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", 64'(busy), 64'(0));
    check("R1 done", 64'(done), 64'(0));
    check("R1 product", product, 64'(0));
    rstN = 1'b1;
    runOp("R4 2x3", 32'd2, 32'd3, 1'b0, 1'b0);
    runOp("R4 ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0);
    runOp("R4 big", 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0);
    runOp("R5 neg6x3", -32'sd6, 32'd3, 1'b1, 1'b0);
    runOp("R5 neg6xneg5", -32'sd6, -32'sd5, 1'b1, 1'b0);
    runOp("R5 zeroxneg", 32'd0, -32'sd7, 1'b1, 1'b0);
    runOp("R5 7xneg1", 32'd7, 32'hFFFF_FFFF, 1'b1, 1'b0);
    runOp("R6 minxmin", 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0);
    runOp("R6 minx1", 32'h8000_0000, 32'd1, 1'b1, 1'b0);
    runOp("R7 R9 restart", 32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1'b1);
    runOp("R7 R9 restart signed", 32'hF00D_0001, 32'h0000_0123, 1'b1, 1'b1);
    begin
      logic [W-1:0] x = 32'hACE1_2357;
      for (int i = 0; i < 6; i++) begin
        x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
        runOp("R4 R5 mix", x, {x[15:0], x[31:16]}, i[0], 1'b0);
      end
    end
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule